// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two 16-bit counting channels, each kept as a low byte and a high byte. A channel either advances once per machine cycle (timer use) or counts falling edges seen on its own input pin (counter use). The machine cycle is twelve system clocks or, with `prescale_fast` high, four system clocks. A free-running phase counter splits each machine cycle into phases. The counts are written on the second-to-last phase. The pins are sampled on the last phase.

Software reaches the block through a single-cycle register port. There is a mode byte, a control byte and the four count bytes. Writes take effect at the next clock edge, and reads are combinational from `reg_addr`. The port has no data stream, so it has no valid/ready handshake and never applies back-pressure. A write is always accepted in the cycle it is presented. Each channel raises an overflow flag when it rolls over. The flag is cleared by software or by a one-cycle acknowledge pulse.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow flags are low.
- R2: A machine cycle lasts 12 clocks when `prescale_fast` is 0 and 4 clocks when it is 1. A running channel in timer use advances exactly once per machine cycle.
- R3: A count byte changes only on the update phase (the second-to-last clock of the machine cycle) or through a register write.
- R4: In counter use, the pin is sampled on the last clock of each machine cycle. A high sample followed by a low sample in the next machine cycle is one falling edge. That edge advances the count on the update phase of the following machine cycle, so a pin needs at least two machine cycles per period to be counted.
- R5: A channel advances only while its run bit is set. When its gate bit is set, it also needs its `gate_pin` bit high.
- R6: Rolling over from the mode's maximum sets that channel's overflow flag, which is visible on `ovf_flag` (bit 0 = channel 0) and in the control byte.
- R7: A flag is cleared by writing 0 to its control-byte bit or by an `ovf_ack` pulse. The acknowledge wins over a write, and a rollover in the same cycle wins over both.
- R8: The register addresses are 0 for mode, 1 for control, 2 and 3 for channel 0 low and high, and 4 and 5 for channel 1 low and high. In the mode byte, bits 7..4 configure channel 1 and bits 3..0 configure channel 0. Each nibble is {gate, pin-count select, mode[1:0]}. The control byte is {flag1, run1, flag0, run0, four stored bits}.
- R9: Mode 00 is a 13-bit counter. The low byte's bits 4..0 act as a prescaler into the high byte, and the low byte's bits 7..5 hold.
- R10: Mode 01 is a full 16-bit counter that wraps from 0xFFFF to 0x0000.
- R11: Mode 10 counts only in the low byte. On rollover from 0xFF it reloads the low byte from the high byte.
- R12: Mode 11 on channel 0 splits it into two 8-bit counters. The low one uses channel 0's controls and flag. The high one counts machine cycles while run1 is set and raises flag 1. In this state, channel 1's own rollovers do not set flag 1. Mode 11 on channel 1 freezes channel 1.
- R13: A write to a count byte in a cycle where that counter would advance loads the written value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale_fast | input | 1 | 1 selects a 4-clock machine cycle, 0 selects 12 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cnt_pin | input | 2 | External count inputs, bit n for channel n |
| gate_pin | input | 2 | External gate inputs, bit n for channel n |
| ovf_ack | input | 2 | Overflow-flag acknowledge, bit n for channel n |
| ovf_flag | output | 2 | Overflow flags, bit n for channel n |

## Verification
Several properties are checked on every cycle. The update and sample phases never coincide, and the sample phase directly follows the update phase. Count bytes stay frozen outside update cycles and writes. A rollover always raises the flag on the next cycle, an acknowledge clears it, and a channel held in mode 11 keeps its value. The exact arithmetic of each mode, the reload value, the one-machine-cycle delay of pin edges, gating, and the write-over-increment priority can only be shown by the bench's scenarios. Those scenarios run against a behavioural model that is compared on every clock.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    CM_13     = 2'b00,
    CM_16     = 2'b01,
    CM_RELOAD = 2'b10,
    CM_SPLIT  = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    cnt_mode_e mode;
  } chan_cfg_t;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;

  localparam int CB_TF1 = 7;
  localparam int CB_TR1 = 6;
  localparam int CB_TF0 = 5;
  localparam int CB_TR0 = 4;
endpackage

// File: rtl/dtu_cycle_gen.sv
module dtu_cycle_gen #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic upd_tick,
  output logic samp_tick
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW = $clog2(MAX_DIV);
  localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);
  localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] last_ph;

  assign last_ph   = fast ? FAST_LAST : SLOW_LAST;
  assign samp_tick = (phase == last_ph);
  assign upd_tick  = (phase == last_ph - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                phase <= '0;
    else if (phase >= last_ph) phase <= '0;
    else                       phase <= phase + PW'(1);
  end
endmodule

// File: rtl/dtu_edge_sampler.sv
module dtu_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic samp_tick,
  input  logic upd_tick,
  output logic pend
);
  logic last_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_s <= 1'b0;
      pend   <= 1'b0;
    end else if (samp_tick) begin
      last_s <= pin;
      if (last_s && !pin) pend <= 1'b1;
    end else if (upd_tick) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dtu_count_core.sv
module dtu_count_core
  import dtu_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cnt_mode_e mode,
  input  logic      inc_main,
  input  logic      inc_hi,
  input  logic      wr_lo,
  input  logic      wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] lo_q,
  output logic [7:0] hi_q,
  output logic      ovf_main,
  output logic      ovf_hi
);
  logic [7:0]  lo_d, hi_d;
  logic [5:0]  pre_sum;
  logic [8:0]  lo_sum, hi_sum;
  logic [16:0] wide_sum;
  logic        wr_any;

  assign wr_any   = wr_lo | wr_hi;
  assign pre_sum  = {1'b0, lo_q[4:0]} + 6'd1;
  assign lo_sum   = {1'b0, lo_q} + 9'd1;
  assign hi_sum   = {1'b0, hi_q} + 9'd1;
  assign wide_sum = {1'b0, hi_q, lo_q} + 17'd1;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    unique case (mode)
      CM_13: begin
        if (inc_main && !wr_any) begin
          lo_d[4:0] = pre_sum[4:0];
          if (pre_sum[5]) begin
            hi_d     = hi_sum[7:0];
            ovf_main = hi_sum[8];
          end
        end
      end
      CM_16: begin
        if (inc_main && !wr_any) {ovf_main, hi_d, lo_d} = wide_sum;
      end
      CM_RELOAD: begin
        if (inc_main && !wr_any) begin
          if (lo_sum[8]) begin
            lo_d     = hi_q;
            ovf_main = 1'b1;
          end else begin
            lo_d = lo_sum[7:0];
          end
        end
      end
      CM_SPLIT: begin
        if (SPLIT_OK) begin
          if (inc_main && !wr_lo) {ovf_main, lo_d} = lo_sum;
          if (inc_hi && !wr_hi)   {ovf_hi, hi_d}   = hi_sum;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dtu_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prescale_fast,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] ovf_ack,
  output logic [1:0] ovf_flag
);
  logic upd_tick, samp_tick;
  logic [7:0] mode_q;
  logic [NCH-1:0] tf_q, tr_q;
  logic [3:0] aux_q;
  logic [NCH-1:0][7:0] lo_byte, hi_byte;
  logic [NCH-1:0] pend, run, inc_main, inc_hi, wr_lo, wr_hi;
  logic [NCH-1:0] ovf_main, ovf_hi, tf_set;
  chan_cfg_t cfg [NCH];
  logic wr_mode, wr_ctrl, split;

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  dtu_cycle_gen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_cyc (
    .clk(clk), .rst_n(rst_n), .fast(prescale_fast),
    .upd_tick(upd_tick), .samp_tick(samp_tick)
  );

  assign split     = (cfg[0].mode == CM_SPLIT);
  assign inc_hi[0] = upd_tick & tr_q[1];
  assign inc_hi[1] = 1'b0;
  assign tf_set[0] = ovf_main[0];
  assign tf_set[1] = (ovf_main[1] & ~split) | ovf_hi[0] | ovf_hi[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [2:0] LO_A = A_LO0 + 3'(2 * g);
    localparam logic [2:0] HI_A = A_HI0 + 3'(2 * g);
    localparam int TF_B = (g == 0) ? CB_TF0 : CB_TF1;

    assign cfg[g]      = chan_cfg_t'(mode_q[4*g +: 4]);
    assign wr_lo[g]    = reg_wr && (reg_addr == LO_A);
    assign wr_hi[g]    = reg_wr && (reg_addr == HI_A);
    assign run[g]      = tr_q[g] & (~cfg[g].gate | gate_pin[g]);
    assign inc_main[g] = upd_tick & run[g] & (~cfg[g].ext | pend[g]);

    dtu_edge_sampler u_es (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin[g]),
      .samp_tick(samp_tick), .upd_tick(upd_tick), .pend(pend[g])
    );

    dtu_count_core #(.SPLIT_OK(g == 0)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(cfg[g].mode),
      .inc_main(inc_main[g]), .inc_hi(inc_hi[g]),
      .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]), .wdata(reg_wdata),
      .lo_q(lo_byte[g]), .hi_q(hi_byte[g]),
      .ovf_main(ovf_main[g]), .ovf_hi(ovf_hi[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tf_q[g] <= 1'b0;
      end else begin
        if (tf_set[g])      tf_q[g] <= 1'b1;
        else if (ovf_ack[g]) tf_q[g] <= 1'b0;
        else if (wr_ctrl)    tf_q[g] <= reg_wdata[TF_B];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      tr_q   <= '0;
      aux_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctrl) begin
        tr_q  <= {reg_wdata[CB_TR1], reg_wdata[CB_TR0]};
        aux_q <= reg_wdata[3:0];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], aux_q};
      A_LO0:   reg_rdata = lo_byte[0];
      A_HI0:   reg_rdata = hi_byte[0];
      A_LO1:   reg_rdata = lo_byte[1];
      A_HI1:   reg_rdata = hi_byte[1];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign ovf_flag = tf_q;
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       prescale_fast,
  input logic       reg_wr,
  input logic       upd_tick,
  input logic       samp_tick,
  input logic [1:0] ovf_main,
  input logic [1:0] ovf_ack,
  input logic [1:0] ovf_flag,
  input logic [1:0] ch1_mode,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  AST_TICKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_tick && samp_tick)); // R2
  AST_SAMPLE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> (samp_tick || !$stable(prescale_fast))); // R2
  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_tick && !reg_wr) |=> ($stable(lo0) && $stable(hi0) && $stable(lo1) && $stable(hi1))); // R3
  AST_OVF_RAISES_FLAG0: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_main[0] |=> ovf_flag[0]); // R6
  AST_ACK_CLEARS_FLAG0: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack[0] && !ovf_main[0]) |=> !ovf_flag[0]); // R7
  AST_CH1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_mode == 2'b11 && !reg_wr) |=> ($stable(lo1) && $stable(hi1))); // R12
endmodule

bind dual_timer_unit dtu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .prescale_fast(prescale_fast), .reg_wr(reg_wr),
  .upd_tick(upd_tick), .samp_tick(samp_tick), .ovf_main(ovf_main),
  .ovf_ack(ovf_ack), .ovf_flag(ovf_flag), .ch1_mode(mode_q[5:4]),
  .lo0(lo_byte[0]), .hi0(hi_byte[0]), .lo1(lo_byte[1]), .hi1(hi_byte[1])
);

// File: tb/dual_timer_unit_bench.sv
module dual_timer_unit_bench;
  timeunit 1ns;
  timeprecision 10ps;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       prescale_fast = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_pin = '0, gate_pin = '0, ovf_ack = '0, ovf_flag;

  int checks = 0, errors = 0;

  dual_timer_unit u_dual_timer_unit (
    .clk(clk), .rst_n(rst_n), .prescale_fast(prescale_fast), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, integer state, updated on each rising edge
  int m_ph, m_mode, m_aux;
  int m_tf[2], m_tr[2], m_lo[2], m_hi[2], m_last[2], m_pend[2];

  always @(posedge clk) begin
    int len, upd, samp, split, g, ext, md, run, ev, wl, wh, v;
    int set[2];
    if (!rst_n) begin
      m_ph = 0; m_mode = 0; m_aux = 0;
      for (int c = 0; c < 2; c++) begin
        m_tf[c] = 0; m_tr[c] = 0; m_lo[c] = 0; m_hi[c] = 0; m_last[c] = 0; m_pend[c] = 0;
      end
    end else begin
      len = prescale_fast ? 4 : 12;
      upd = (m_ph == len - 2);
      samp = (m_ph == len - 1);
      split = ((m_mode & 3) == 3);
      set[0] = 0; set[1] = 0;
      for (int c = 0; c < 2; c++) begin
        g   = (m_mode >> (4*c + 3)) & 1;
        ext = (m_mode >> (4*c + 2)) & 1;
        md  = (m_mode >> (4*c)) & 3;
        run = m_tr[c] && (!g || gate_pin[c]);
        ev  = upd && run && (!ext || m_pend[c]);
        wl  = reg_wr && (reg_addr == 2 + 2*c);
        wh  = reg_wr && (reg_addr == 3 + 2*c);
        if (md == 3) begin
          if (c == 0) begin
            if (ev && !wl) begin
              m_lo[0] = m_lo[0] + 1;
              if (m_lo[0] == 256) begin m_lo[0] = 0; set[0] = 1; end
            end
            if (upd && m_tr[1] && !wh) begin
              m_hi[0] = m_hi[0] + 1;
              if (m_hi[0] == 256) begin m_hi[0] = 0; set[1] = 1; end
            end
          end
        end else if (ev && !wl && !wh) begin
          v = 0;
          if (md == 1) begin
            v = m_hi[c] * 256 + m_lo[c] + 1;
            if (v == 65536) begin v = 0; set[c] = 1; end
            m_hi[c] = v / 256; m_lo[c] = v % 256;
          end else if (md == 0) begin
            v = (m_lo[c] % 32) + 1;
            if (v == 32) begin
              v = 0;
              m_hi[c] = m_hi[c] + 1;
              if (m_hi[c] == 256) begin m_hi[c] = 0; set[c] = 1; end
            end
            m_lo[c] = (m_lo[c] / 32) * 32 + v;
          end else begin
            if (m_lo[c] == 255) begin m_lo[c] = m_hi[c]; set[c] = 1; end
            else m_lo[c] = m_lo[c] + 1;
          end
          if (c == 1 && split) set[1] = 0;
        end
        if (wl) m_lo[c] = reg_wdata;
        if (wh) m_hi[c] = reg_wdata;
      end
      for (int c = 0; c < 2; c++) begin
        if (reg_wr && reg_addr == 1) m_tf[c] = reg_wdata[c ? 7 : 5];
        if (ovf_ack[c]) m_tf[c] = 0;
        if (set[c]) m_tf[c] = 1;
      end
      if (reg_wr && reg_addr == 1) begin
        m_tr[0] = reg_wdata[4]; m_tr[1] = reg_wdata[6]; m_aux = reg_wdata[3:0];
      end
      if (reg_wr && reg_addr == 0) m_mode = reg_wdata;
      for (int c = 0; c < 2; c++) begin
        if (samp) begin
          if (m_last[c] && !cnt_pin[c]) m_pend[c] = 1;
          m_last[c] = cnt_pin[c];
        end else if (upd) m_pend[c] = 0;
      end
      m_ph = (m_ph >= len - 1) ? 0 : m_ph + 1;
    end
  end

  function automatic int model_read(logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return m_tf[1]*128 + m_tr[1]*64 + m_tf[0]*32 + m_tr[0]*16 + m_aux;
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R3 model compare", reg_rdata, model_read(reg_addr));
      chk("R6 model flags", ovf_flag, m_tf[1]*2 + m_tf[0]);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(int a, int exp, string tag);
    reg_addr = 3'(a);
    #0.2;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 0, "R1 mode"); rd(1, 0, "R1 ctrl"); rd(2, 0, "R1 lo0");
    idle(1);
    rd(3, 0, "R1 hi0"); rd(4, 0, "R1 lo1"); rd(5, 0, "R1 hi1");
    chk("R1 flags", ovf_flag, 0);

    // R10 R2 R6: 16-bit wrap, slow machine cycle
    wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h10);
    idle(24);
    rd(2, 0, "R10 lo wrap"); rd(3, 0, "R10 hi wrap (R2 two ticks in 24 clocks)");
    chk("R6 flag0 after wrap", ovf_flag[0], 1);
    ovf_ack = 2'b01; idle(1); ovf_ack = 2'b00;
    chk("R7 ack clears flag0", ovf_flag[0], 0);

    // R2 fast rate, R3 stopped channel holds
    wr(1, 8'h00);
    prescale_fast = 1'b1;
    wr(2, 0); wr(3, 0);
    idle(40);
    rd(2, 0, "R3 stopped channel holds");
    wr(1, 8'h10);
    idle(40);
    rd(2, 10, "R2 ten ticks in 40 fast clocks");

    // R4 pin counting
    wr(1, 8'h00); wr(0, 8'h05); wr(2, 0); wr(1, 8'h10);
    for (int i = 0; i < 5; i++) begin
      cnt_pin[0] = 1'b1; idle(4);
      cnt_pin[0] = 1'b0; idle(4);
    end
    idle(12);
    rd(2, 5, "R4 five pin edges");

    // R5 gating
    wr(1, 8'h00); wr(0, 8'h09); wr(2, 0); gate_pin[0] = 1'b0; wr(1, 8'h10);
    idle(40);
    rd(2, 0, "R5 gate low blocks");
    gate_pin[0] = 1'b1;
    idle(40);
    rd(2, 10, "R5 gate high runs");

    // R9 13-bit mode
    wr(1, 8'h00); gate_pin[0] = 1'b0;
    wr(0, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h10);
    idle(8);
    rd(2, 8'hE0, "R9 prescaler wrap keeps upper bits"); rd(3, 0, "R9 high wrap");
    chk("R6 flag0 on 13-bit wrap", ovf_flag[0], 1);
    wr(1, 8'h00);
    chk("R7 software clear flag0", ovf_flag[0], 0);

    // R11 auto-reload on channel 1
    wr(0, 8'h20); wr(4, 8'hFE); wr(5, 8'h80); wr(1, 8'h40);
    idle(12);
    rd(4, 8'h81, "R11 reload then count"); rd(5, 8'h80, "R11 reload source kept");
    chk("R6 flag1 on reload", ovf_flag, 2'b10);

    // R12 split channel 0, channel 1 frozen
    wr(1, 8'h00);
    ovf_ack = 2'b11; idle(1); ovf_ack = 2'b00;
    wr(0, 8'h33); wr(2, 0); wr(3, 0); wr(4, 8'h55); wr(1, 8'h50);
    idle(20);
    rd(2, 5, "R12 split low"); rd(3, 5, "R12 split high"); rd(4, 8'h55, "R12 ch1 frozen");
    wr(3, 8'hFF);
    idle(4);
    rd(3, 0, "R12 split high wrap");
    chk("R12 split high sets flag1", ovf_flag[1], 1);

    // R13 write beats increment
    wr(1, 8'h00); wr(0, 8'h01); wr(3, 8'h12); wr(1, 8'h10);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h40;
    idle(8);
    reg_wr = 1'b0;
    rd(2, 8'h40, "R13 write wins low"); rd(3, 8'h12, "R13 high untouched");

    // R8 control byte layout
    wr(1, 8'hAF);
    rd(1, 8'hAF, "R8 control readback"); rd(0, 8'h01, "R8 mode readback");
    chk("R8 flag bits map to ovf_flag", ovf_flag, 2'b11);

    idle(4);
    finish_run();
  end
endmodule